// File: doc/BRIEF.md
# Round-Key Generator with Shift-Register Sequence

This block derives twenty 64-bit round keys from a 128-bit master key for a 20-round Feistel datapath. A load strobe captures the master key: its upper half seeds a 64-bit linear feedback shift register and its lower half is held as a fixed mask. The key for the current round is the XOR of three values: the fixed mask, the current shift-register state and a per-round constant taken from a built-in table. No substitution step is involved.

The consumer reads the round key and the round index while the valid flag is high. It pulses the advance strobe once it has used a key, and the register then steps once to produce the key for the next round. After the twentieth key has been consumed, the valid flag drops and the block waits for the next load.

Top module: `round_key_gen`

## Requirements
- R1: After reset, `key_valid_o` is 0 and `round_idx_o` is 0.
- R2: In the cycle after `load_i` is sampled high, `key_valid_o` is 1, `round_idx_o` is 0 and the shift-register state equals `master_key_i[127:64]`.
- R3: Each `advance_i` sampled while `key_valid_o` is 1 (and `load_i` is 0) steps the register once and increments `round_idx_o`. A step shifts the state right by one bit, and the new bit 63 is the XOR of the old bits 0, 1, 3 and 4. This is the polynomial x^64+x^4+x^3+x+1.
- R4: `round_key_o` equals `master_key_i[63:0]` XOR the current state XOR C[`round_idx_o`]. C[0]..C[19] are consecutive 16-hex-digit groups of the hexadecimal fraction of pi, beginning 243F6A8885A308D3, 13198A2E03707344, and so on.
- R5: The lower key half captured at load is used unchanged for all twenty rounds.
- R6: A zero upper key half keeps the register at zero with no substitution. The keys are then the lower half XOR C[r] and still differ from round to round.
- R7: The advance that consumes the key of round 19 clears `key_valid_o`. `round_idx_o` then stays at 19, `round_key_o` keeps its last value, and later advances change nothing.
- R8: `advance_i` has no effect while `key_valid_o` is 0, including before the first load.
- R9: `load_i` restarts the sequence at any time and takes priority over an `advance_i` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Capture master key and restart at round 0 |
| master_key_i | input | 128 | Master key; upper half seeds the register, lower half is the mask |
| advance_i | input | 1 | Current round key consumed; step to next round |
| round_idx_o | output | 5 | Index of the round whose key is presented |
| round_key_o | output | 64 | Round key for `round_idx_o` |
| key_valid_o | output | 1 | Round key is valid |

## Verification
All state changes on the rising edge that samples a strobe. The round key is a combinational function of that registered state, so each result is due exactly one edge after the `load_i` or `advance_i` that caused it. The bench drives strobes on the falling edge and samples on the following falling edge, one full edge later. There it compares against a model that steps its own copy of the register and its own constant table. Checks that a strobe is ignored sample the same outputs one edge after the ignored pulse and expect no change.

// File: rtl/round_key_gen.sv
module round_key_gen #(
  parameter int KEY_W  = 128,
  parameter int ROUNDS = 20
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      load_i,
  input  logic [KEY_W-1:0]          master_key_i,
  input  logic                      advance_i,
  output logic [$clog2(ROUNDS)-1:0] round_idx_o,
  output logic [KEY_W/2-1:0]        round_key_o,
  output logic                      key_valid_o
);
  localparam int HW = KEY_W / 2;
  localparam int RW = $clog2(ROUNDS);
  localparam logic [RW-1:0] LAST = RW'(ROUNDS - 1);

  logic [HW-1:0] sreg, kmask;
  logic [RW-1:0] rnd;
  logic          vld;

  function automatic logic [63:0] rconst(input logic [RW-1:0] i);
    case (i)
      0:  rconst = 64'h243F6A8885A308D3;
      1:  rconst = 64'h13198A2E03707344;
      2:  rconst = 64'hA4093822299F31D0;
      3:  rconst = 64'h082EFA98EC4E6C89;
      4:  rconst = 64'h452821E638D01377;
      5:  rconst = 64'hBE5466CF34E90C6C;
      6:  rconst = 64'hC0AC29B7C97C50DD;
      7:  rconst = 64'h3F84D5B5B5470917;
      8:  rconst = 64'h9216D5D98979FB1B;
      9:  rconst = 64'hD1310BA698DFB5AC;
      10: rconst = 64'h2FFD72DBD01ADFB7;
      11: rconst = 64'hB8E1AFED6A267E96;
      12: rconst = 64'hBA7C9045F12C7F99;
      13: rconst = 64'h24A19947B3916CF7;
      14: rconst = 64'h0801F2E2858EFC16;
      15: rconst = 64'h636920D871574E69;
      16: rconst = 64'hA458FEA3F4933D7E;
      17: rconst = 64'h0D95748F728EB658;
      18: rconst = 64'h718BCD5882154AEE;
      19: rconst = 64'h7B54A41DC25A59B5;
      default: rconst = 64'h0;
    endcase
  endfunction

  wire          step   = vld && advance_i && !load_i;
  wire [HW-1:0] sreg_n = {sreg[0] ^ sreg[1] ^ sreg[3] ^ sreg[4], sreg[HW-1:1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg  <= '0;
      kmask <= '0;
      rnd   <= '0;
      vld   <= 1'b0;
    end else if (load_i) begin
      sreg  <= master_key_i[KEY_W-1:HW];
      kmask <= master_key_i[HW-1:0];
      rnd   <= '0;
      vld   <= 1'b1;
    end else if (step) begin
      if (rnd == LAST) begin
        vld <= 1'b0;
      end else begin
        sreg <= sreg_n;
        rnd  <= rnd + 1'b1;
      end
    end
  end

  assign round_idx_o = rnd;
  assign key_valid_o = vld;
  assign round_key_o = kmask ^ sreg ^ HW'(rconst(rnd));

  always_comb begin
    if (rst_n) begin
      p_round_in_range_r3: assert (rnd <= LAST);
    end
  end

  p_load_starts_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (vld && rnd == '0 && sreg == $past(master_key_i[KEY_W-1:HW])));

  p_step_shift_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && rnd != LAST) |=> (rnd == $past(rnd) + 1'b1 && sreg[HW-2:0] == $past(sreg[HW-1:1])));

  p_mask_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(kmask));

  p_zero_stays_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sreg == '0 && !load_i) |=> sreg == '0);

  p_last_drops_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (step && rnd == LAST) |=> (!vld && rnd == LAST));

  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!vld && !load_i) |=> (!vld && $stable(rnd) && $stable(sreg)));
endmodule

// File: tb/round_key_gen_tb.sv
module round_key_gen_tb;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         load_i = 1'b0;
  logic [127:0] master_key_i = '0;
  logic         advance_i = 1'b0;
  logic [4:0]   round_idx_o;
  logic [63:0]  round_key_o;
  logic         key_valid_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  round_key_gen u_dut (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .master_key_i(master_key_i),
    .advance_i(advance_i), .round_idx_o(round_idx_o),
    .round_key_o(round_key_o), .key_valid_o(key_valid_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [63:0] pi_c(input int i);
    logic [63:0] t [20] = '{
      64'h243F6A8885A308D3, 64'h13198A2E03707344, 64'hA4093822299F31D0,
      64'h082EFA98EC4E6C89, 64'h452821E638D01377, 64'hBE5466CF34E90C6C,
      64'hC0AC29B7C97C50DD, 64'h3F84D5B5B5470917, 64'h9216D5D98979FB1B,
      64'hD1310BA698DFB5AC, 64'h2FFD72DBD01ADFB7, 64'hB8E1AFED6A267E96,
      64'hBA7C9045F12C7F99, 64'h24A19947B3916CF7, 64'h0801F2E2858EFC16,
      64'h636920D871574E69, 64'hA458FEA3F4933D7E, 64'h0D95748F728EB658,
      64'h718BCD5882154AEE, 64'h7B54A41DC25A59B5};
    return t[i];
  endfunction

  function automatic logic [63:0] lfsr_next(input logic [63:0] s);
    logic fb = s[0] ^ s[1] ^ s[3] ^ s[4];
    return {fb, s[63:1]};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic pulse_load(input logic [127:0] k, input logic adv);
    master_key_i = k; load_i = 1'b1; advance_i = adv;
    @(negedge clk);
    load_i = 1'b0; advance_i = 1'b0;
  endtask

  task automatic pulse_adv();
    advance_i = 1'b1;
    @(negedge clk);
    advance_i = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 valid", 64'(key_valid_o), 64'd0);
    check("R1 round", 64'(round_idx_o), 64'd0);
  endtask

  task automatic t_idle_advance();
    pulse_adv();
    pulse_adv();
    check("R8 valid", 64'(key_valid_o), 64'd0);
    check("R8 round", 64'(round_idx_o), 64'd0);
  endtask

  task automatic t_full_run(input logic [127:0] k, input string req);
    logic [63:0] s = k[127:64];
    logic [63:0] last = '0;
    pulse_load(k, 1'b0);
    check("R2 valid", 64'(key_valid_o), 64'd1);
    for (int i = 0; i < 20; i++) begin
      check({req, " R3 round"}, 64'(round_idx_o), 64'(i));
      check({req, " R4 R5 key"}, round_key_o, k[63:0] ^ s ^ pi_c(i));
      check({req, " valid"}, 64'(key_valid_o), 64'd1);
      last = round_key_o;
      s = lfsr_next(s);
      pulse_adv();
    end
    check("R7 valid", 64'(key_valid_o), 64'd0);
    check("R7 round", 64'(round_idx_o), 64'd19);
    check("R7 key", round_key_o, last);
    repeat (3) pulse_adv();
    check("R7 ignored round", 64'(round_idx_o), 64'd19);
    check("R7 ignored key", round_key_o, last);
    check("R7 ignored valid", 64'(key_valid_o), 64'd0);
  endtask

  task automatic t_zero_high();
    logic [63:0] lo = 64'h0123_4567_89AB_CDEF;
    logic [63:0] prev = '0;
    pulse_load({64'd0, lo}, 1'b0);
    for (int i = 0; i < 20; i++) begin
      check("R6 key", round_key_o, lo ^ pi_c(i));
      if (i > 0) checks++;
      if (i > 0 && round_key_o == prev) begin
        fails++;
        $display("FAIL R6 repeat: actual %h expected differ from %h", round_key_o, prev);
      end
      prev = round_key_o;
      pulse_adv();
    end
  endtask

  task automatic t_restart();
    logic [127:0] k2 = 128'hFEDC_BA98_7654_3210_0F1E_2D3C_4B5A_6978;
    pulse_load(128'h1111_2222_3333_4444_5555_6666_7777_8888, 1'b0);
    repeat (5) pulse_adv();
    check("R9 mid round", 64'(round_idx_o), 64'd5);
    pulse_load(k2, 1'b1);
    check("R9 round", 64'(round_idx_o), 64'd0);
    check("R9 key", round_key_o, k2[127:64] ^ k2[63:0] ^ pi_c(0));
    check("R9 valid", 64'(key_valid_o), 64'd1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_idle_advance();
    t_full_run(128'hA5A5_0F0F_DEAD_BEEF_0000_1111_2222_3333, "k1");
    t_full_run(128'h8000_0000_0000_0001_FFFF_FFFF_FFFF_FFFF, "k2");
    t_zero_high();
    t_restart();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule